// File: doc/BRIEF.md
# Column Compression Tree with Generate/Propagate Output

This block is the middle stage of a radix-4 recoded multiplier. It takes the partial-product bits, already grouped by binary weight, and reduces every weight column with a chain of full adders. Carries that leave a column enter the next more significant column as ordinary full-adder inputs, alongside that column's own bits. Each column is reduced until at most two bits remain. A final two-input cell then turns that pair into a propagate bit (the exclusive-OR) and a generate bit (the AND). The result goes straight into a lookahead adder, and no separate generate/propagate stage is needed in front of it.

The block is purely combinational. The column heights follow from the operand width at elaboration time. There are `OP_WIDTH/2+1` recoded rows. Row `r` spans columns `2r` to `2r+OP_WIDTH+1`, and it also places one negate bit in column `2r`. The output has as many columns as are needed for every carry to be absorbed.

Top module: `column_compress_gp`

## Requirements
- R1: `bitsIn` packs columns in ascending order from bit 0, each column taking a contiguous slice. The height of column `c` is the number of rows `r` (with `0 <= r <= OP_WIDTH/2`) for which `2r <= c <= 2r+OP_WIDTH+1`, plus one for every row with `2r == c`. At `OP_WIDTH=8` there are 18 input columns and 55 bits in total.
- R2: The outputs hold one generate bit and one propagate bit per output column, with bit `c` having weight `2^c`. The number of output columns is the number of input columns, extended while carries are still leaving the top column (18 at `OP_WIDTH=8`). The outputs follow the inputs with no clock.
- R3: The sum over all columns of `(propOut[c] + 2*genOut[c]) * 2^c` equals the sum of every set input bit weighted by `2^(its column)`.
- R4: In every column, `genOut[c]` and `propOut[c]` are never both 1.
- R5: An all-zero input gives all-zero `genOut` and `propOut`.
- R6: When exactly one input bit is set, `propOut` has a single 1 at that bit's column and `genOut` is zero.
- R7: Setting every bit of one column `c` (and nothing else) yields an output value of `height(c) * 2^c`, so no bit of a column is dropped, including in the tallest column of `OP_WIDTH/2+2` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitsIn | input | totalBits(OP_WIDTH) | Partial-product bits packed column by column, least significant column first |
| genOut | output | outCols(OP_WIDTH) | Per-column carry-generate bit (AND of the column's final pair) |
| propOut | output | outCols(OP_WIDTH) | Per-column propagate/sum bit (XOR of the column's final pair) |

## Verification
The bound checker evaluates four properties on every input change:
- weighted-value preservation between the packed input and the generate/propagate pairs;
- mutual exclusion of generate and propagate in each column;
- zero in, zero out;
- a lone set bit reaching the output as a single propagate bit with no generate.

Some behaviours only the directed scenarios can show. One is the packing order and height of each column, shown by walking a single bit across every input position and seeing where it lands. Another is that the tallest columns lose nothing when completely filled. A third is that the outputs track input changes within the same cycle.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;

  function automatic int rowCount(input int w);
    return w / 2 + 1;
  endfunction

  function automatic int rowSpan(input int w);
    return w + 2;
  endfunction

  function automatic int inCols(input int w);
    return 2 * (rowCount(w) - 1) + rowSpan(w);
  endfunction

  // Bits in column c from the recoded row layout (rows plus negate bits)
  function automatic int colHeight(input int w, input int c);
    int cnt;
    cnt = 0;
    for (int r = 0; r < rowCount(w); r++) begin
      if (c >= 2 * r && c < 2 * r + rowSpan(w)) cnt++;
      if (c == 2 * r) cnt++;
    end
    return cnt;
  endfunction

  function automatic int colOffset(input int w, input int c);
    int off;
    off = 0;
    for (int j = 0; j < c; j++) off += colHeight(w, j);
    return off;
  endfunction

  function automatic int totalBits(input int w);
    return colOffset(w, inCols(w));
  endfunction

  function automatic int bitColumn(input int w, input int idx);
    int col;
    col = 0;
    for (int c = 0; c < inCols(w); c++) begin
      if (idx >= colOffset(w, c) && idx < colOffset(w, c) + colHeight(w, c)) col = c;
    end
    return col;
  endfunction

  // Full adders needed to bring n bits down to at most two
  function automatic int faNeeded(input int n);
    return (n > 2) ? (n - 1) / 2 : 0;
  endfunction

  // Carries leaving column c (one per full adder in that column)
  function automatic int carriesOut(input int w, input int c);
    int k;
    k = 0;
    for (int j = 0; j <= c; j++) k = faNeeded(colHeight(w, j) + k);
    return k;
  endfunction

  function automatic int outCols(input int w);
    int cols;
    cols = inCols(w);
    for (int j = inCols(w); j < inCols(w) + 64; j++) begin
      if (j == cols && carriesOut(w, j - 1) > 0) cols = j + 1;
    end
    return cols;
  endfunction

  function automatic int carryBase(input int w, input int c);
    int b;
    b = 0;
    for (int j = 0; j < c; j++) b += carriesOut(w, j);
    return b;
  endfunction

endpackage

// File: rtl/cct_fa.sv
`timescale 1ns/1ps
module cct_fa (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic sumOut,
  output logic carryOut
);
  logic halfX;
  assign halfX    = inA ^ inB;
  assign sumOut   = halfX ^ inC;
  assign carryOut = halfX ? inC : inA;
endmodule

// File: rtl/cct_gp_cell.sv
`timescale 1ns/1ps
module cct_gp_cell (
  input  logic bitX,
  input  logic bitY,
  output logic genBit,
  output logic propBit
);
  assign propBit = bitX ^ bitY;
  assign genBit  = bitX & bitY;
endmodule

// File: rtl/cct_reduce_array.sv
`timescale 1ns/1ps
module cct_reduce_array import cct_pkg::*; #(
  parameter  int OP_WIDTH  = 8,
  localparam int BITS_W    = totalBits(OP_WIDTH),
  localparam int OUT_COLS  = outCols(OP_WIDTH),
  localparam int CARRY_TOT = carryBase(OP_WIDTH, OUT_COLS),
  localparam int CARRY_W   = (CARRY_TOT > 0) ? CARRY_TOT : 1
) (
  input  logic [BITS_W-1:0]   bitsIn,
  output logic [OUT_COLS-1:0] genOut,
  output logic [OUT_COLS-1:0] propOut
);

  logic [CARRY_W-1:0] carryBus;

  for (genvar c = 0; c < OUT_COLS; c++) begin : g_col
    localparam int H     = colHeight(OP_WIDTH, c);
    localparam int KIN   = (c == 0) ? 0 : carriesOut(OP_WIDTH, c - 1);
    localparam int N     = H + KIN;
    localparam int F     = faNeeded(N);
    localparam int OFF   = colOffset(OP_WIDTH, c);
    localparam int COFF  = carryBase(OP_WIDTH, c);
    localparam int CIOFF = (c == 0) ? 0 : carryBase(OP_WIDTH, c - 1);

    if (N == 0) begin : g_empty
      assign genOut[c]  = 1'b0;
      assign propOut[c] = 1'b0;
    end else begin : g_live
      // Work list: incoming carries first, own bits next, adder sums appended
      logic [N+F-1:0] item;

      if (KIN > 0) begin : g_cin
        assign item[KIN-1:0] = carryBus[CIOFF +: KIN];
      end
      if (H > 0) begin : g_own
        assign item[KIN +: H] = bitsIn[OFF +: H];
      end

      for (genvar k = 0; k < F; k++) begin : g_fa
        cct_fa fa_i (
          .inA     (item[3*k]),
          .inB     (item[3*k+1]),
          .inC     (item[3*k+2]),
          .sumOut  (item[N+k]),
          .carryOut(carryBus[COFF+k])
        );
      end

      if (N - 2 * F == 2) begin : g_pair
        cct_gp_cell gp_i (
          .bitX   (item[3*F]),
          .bitY   (item[3*F+1]),
          .genBit (genOut[c]),
          .propBit(propOut[c])
        );
      end else begin : g_single
        cct_gp_cell gp_i (
          .bitX   (item[3*F]),
          .bitY   (1'b0),
          .genBit (genOut[c]),
          .propBit(propOut[c])
        );
      end
    end
  end

endmodule

// File: rtl/column_compress_gp.sv
`timescale 1ns/1ps
module column_compress_gp import cct_pkg::*; #(
  parameter  int OP_WIDTH = 8,
  localparam int BITS_W   = totalBits(OP_WIDTH),
  localparam int OUT_COLS = outCols(OP_WIDTH)
) (
  input  logic [BITS_W-1:0]   bitsIn,
  output logic [OUT_COLS-1:0] genOut,
  output logic [OUT_COLS-1:0] propOut
);

  cct_reduce_array #(.OP_WIDTH(OP_WIDTH)) array_i (
    .bitsIn (bitsIn),
    .genOut (genOut),
    .propOut(propOut)
  );

endmodule

// File: rtl/cct_checker.sv
`timescale 1ns/1ps
module cct_checker import cct_pkg::*; #(
  parameter  int OP_WIDTH = 8,
  localparam int BITS_W   = totalBits(OP_WIDTH),
  localparam int OUT_COLS = outCols(OP_WIDTH)
) (
  input logic [BITS_W-1:0]   bitsIn,
  input logic [OUT_COLS-1:0] genOut,
  input logic [OUT_COLS-1:0] propOut
);

  logic [63:0] inTerm [BITS_W];
  logic [63:0] inSum;
  logic [63:0] outSum;

  for (genvar i = 0; i < BITS_W; i++) begin : g_term
    localparam int COL = bitColumn(OP_WIDTH, i);
    assign inTerm[i] = {63'd0, bitsIn[i]} << COL;
  end

  always_comb begin
    inSum = '0;
    for (int i = 0; i < BITS_W; i++) inSum += inTerm[i];
    outSum = '0;
    for (int c = 0; c < OUT_COLS; c++) begin
      outSum += ({63'd0, propOut[c]} << c) + ({63'd0, genOut[c]} << (c + 1));
    end
  end

  always_comb begin
    a_r3_value_kept : assert (inSum == outSum)
      else $error("R3 weighted value mismatch in=%0d out=%0d", inSum, outSum);
    a_r4_gp_exclusive : assert ((genOut & propOut) == '0)
      else $error("R4 generate and propagate both set");
    if (bitsIn == '0) begin
      a_r5_zero_out : assert (genOut == '0 && propOut == '0)
        else $error("R5 nonzero output for zero input");
    end
    if ($countones(bitsIn) == 1) begin
      a_r6_lone_bit : assert ($countones(propOut) == 1 && genOut == '0)
        else $error("R6 lone bit did not surface as one propagate bit");
    end
  end

endmodule

bind column_compress_gp cct_checker #(.OP_WIDTH(OP_WIDTH)) chk_i (
  .bitsIn (bitsIn),
  .genOut (genOut),
  .propOut(propOut)
);

// File: tb/column_compress_gp_tb_top.sv
`timescale 1ns/1ps
module column_compress_gp_tb_top;
  import cct_pkg::*;

  localparam int W  = 8;
  localparam int NB = totalBits(W);
  localparam int NO = outCols(W);

  logic clk = 1'b0;
  logic benchRst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NB-1:0] bitsIn;
  logic [NO-1:0] genOut, propOut;

  int checks = 0;
  int fails  = 0;

  column_compress_gp #(.OP_WIDTH(W)) dut_i (
    .bitsIn (bitsIn),
    .genOut (genOut),
    .propOut(propOut)
  );

  // Layout model written from R1
  function automatic int tbHeight(input int c);
    int h;
    h = 0;
    for (int r = 0; r <= W / 2; r++) begin
      if (c >= 2 * r && c <= 2 * r + W + 1) h++;
      if (c == 2 * r) h++;
    end
    return h;
  endfunction

  function automatic int tbColOf(input int idx);
    int acc;
    int col;
    acc = 0;
    col = -1;
    for (int c = 0; c < 2 * (W / 2) + W + 2; c++) begin
      if (col < 0 && idx < acc + tbHeight(c)) col = c;
      acc += tbHeight(c);
    end
    return col;
  endfunction

  function automatic longint inValue(input logic [NB-1:0] v);
    longint s;
    s = 0;
    for (int i = 0; i < NB; i++) if (v[i]) s += longint'(1) << tbColOf(i);
    return s;
  endfunction

  function automatic longint outValue();
    longint s;
    s = 0;
    for (int c = 0; c < NO; c++) begin
      if (propOut[c]) s += longint'(1) << c;
      if (genOut[c])  s += longint'(2) << c;
    end
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [NB-1:0] v);
    @(posedge clk);
    bitsIn = v;
    @(negedge clk);
  endtask

  task automatic t_zero();
    apply('0);
    check("R5 gen zero", longint'(genOut), 0);
    check("R5 prop zero", longint'(propOut), 0);
    check("R3 zero value", outValue(), 0);
  endtask

  task automatic t_shape();
    check("R1 total input bits", NB, 55);
    check("R2 output columns", NO, 18);
  endtask

  task automatic t_walk_single();
    for (int i = 0; i < NB; i++) begin
      logic [NB-1:0] v;
      v = '0;
      v[i] = 1'b1;
      apply(v);
      check("R1 R6 lone bit column", longint'(propOut), longint'(1) << tbColOf(i));
      check("R6 lone bit no generate", longint'(genOut), 0);
    end
  endtask

  task automatic t_column_fill();
    for (int c = 0; c < 2 * (W / 2) + W + 2; c++) begin
      logic [NB-1:0] v;
      v = '0;
      for (int i = 0; i < NB; i++) if (tbColOf(i) == c) v[i] = 1'b1;
      apply(v);
      check("R7 full column value", outValue(), longint'(tbHeight(c)) << c);
    end
  endtask

  task automatic t_all_ones();
    apply('1);
    check("R3 all ones value", outValue(), inValue('1));
    check("R4 all ones exclusive", longint'(genOut & propOut), 0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      logic [NB-1:0] v;
      for (int i = 0; i < NB; i++) v[i] = $urandom_range(1, 0) == 1;
      apply(v);
      check("R3 random value", outValue(), inValue(v));
      check("R4 random exclusive", longint'(genOut & propOut), 0);
    end
  endtask

  task automatic t_follow();
    logic [NB-1:0] v;
    v = '0;
    v[NB-1] = 1'b1;
    v[0] = 1'b1;
    apply(v);
    check("R2 follows input", outValue(), inValue(v));
    apply('0);
    check("R2 returns to zero", outValue(), 0);
  endtask

  initial begin
    bitsIn = '0;
    repeat (2) @(posedge clk);
    benchRst = 1'b0;
    t_shape();
    t_zero();
    t_walk_single();
    t_column_fill();
    t_all_ones();
    t_follow();
    t_random();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule